// File: doc/BRIEF.md
# DMA interrupt and status register bank

This block is the software-visible interrupt and status side of a multi-channel DMA controller with up to eight channels. It keeps one raw terminal-count flag and one raw error flag per channel. The transfer engine raises these flags through single-cycle set pulses, and software clears them by writing ones. The block also holds one configuration word per channel. Bit 15 of that word is the channel's terminal-count mask, bit 14 is its error mask, and bit 0 is its enable, which goes out to the transfer engine. A single level interrupt is high while any unmasked flag is set.

Software reaches the bank through a 32-bit register port addressed by word offset, which is the byte offset divided by four. A read is accepted in the cycle `rd_en` is high. A small access state machine returns the result in the next cycle. It has three states:
- `ACC_IDLE`: no response is pending.
- `ACC_DATA`: valid read data is returned.
- `ACC_FAULT`: the offset was unmapped, so zero data is returned with `slverr`.

Each cycle the machine moves to `ACC_DATA` on a read of a mapped offset, to `ACC_FAULT` on a read of an unmapped offset, and to `ACC_IDLE` when there is no read, whatever its current state. The bank also provides:
- the global configuration (controller enable and two master endianness selects) and a sync-select register, both driven out to the engine;
- an enabled-channel bitmap;
- a read-only identification area.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset all flags, channel configuration words, global configuration and sync select are zero, `irq`, `rd_valid` and `slverr` are low, and every output bus is zero.
- R2: A high bit in `tc_set` or `err_set` sets that channel's raw terminal-count or raw error flag on the next clock edge. The flag stays set until it is cleared.
- R3: Writing to word 2 clears each raw terminal-count flag whose bit in `wdata` is 1. Writing to word 4 does the same for raw error flags. Flags whose `wdata` bit is 0 are unchanged.
- R4: When a set pulse and a clear of the same flag occur in the same cycle, the flag is set afterwards.
- R5: Masked reads are built from the masks. Word 1 returns raw terminal-count AND the terminal-count masks (configuration bit 15). Word 3 returns raw error AND the error masks (configuration bit 14). Word 0 returns the OR of the two. Bits at and above `NUM_CH` read zero.
- R6: `irq` is high exactly when word 0 would read non-zero. It updates in the cycle after the flag or mask change.
- R7: Word 5 returns the raw terminal-count flags and word 6 returns the raw error flags, whatever the masks are.
- R8: The configuration word of channel c sits at word 0x44 + 8·c and reads back all 32 written bits. `ch_enable[c]` and bit c of word 7 both equal its bit 0. Only channels below `NUM_CH` exist.
- R9: Word 12 holds the global configuration: bit 0 is the controller enable (`dma_on`) and bits 2:1 are the master endianness selects (`master_bigend`); upper bits read zero. Word 13 holds `SYNC_W` sync-select bits (`sync_sel`), and upper bits read zero.
- R10: Words 8 to 11 read as zero without error, and writes to them change nothing.
- R11: Words 0x3F8 to 0x3FF return identification bytes, one per word. The first byte is 0x80 when `NUM_CH` > 2 and 0x81 otherwise. It is followed by 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Read data and `rd_valid` appear in the cycle after `rd_en`. `rd_valid` is low in any cycle that does not follow a read.
- R13: A read of any other offset returns zero with `slverr` high for that one response cycle. The unmapped offsets include words 2 and 4, the non-configuration channel words, and channels at or above `NUM_CH`. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Word offset (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read response cycle |
| slverr | output | 1 | Read hit an unmapped offset |
| tc_set | input | NUM_CH | Terminal-count set pulses from the engine |
| err_set | input | NUM_CH | Error set pulses from the engine |
| ch_enable | output | NUM_CH | Channel enable bits to the engine |
| dma_on | output | 1 | Controller enable |
| master_bigend | output | 2 | Master endianness selects |
| sync_sel | output | SYNC_W | Sync-select bits |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench reads all 1024 word offsets several times against a model of the register state. A wrong decode therefore shows up as a mapped word that faults, or an unmapped word that returns data. Examples are a read of a clear-only word that returns data, or a configuration word answered for a channel that does not exist. For every channel, it goes through all four combinations of the two mask bits with terminal-count and error pulses. This shows whether the masks were taken from the wrong bit or swapped, because the wrong masked view or a spurious `irq` would follow. It also applies a set pulse in the same cycle as a clear of that flag. A design that lets the clear win would read the flag back as zero.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_DATA  = 2'd1,
        ACC_FAULT = 2'd2
    } acc_state_t;

    localparam int WORD_AW = 10;

    // global word offsets
    localparam logic [WORD_AW-1:0] OFS_STAT_ALL = 10'd0;
    localparam logic [WORD_AW-1:0] OFS_STAT_TC  = 10'd1;
    localparam logic [WORD_AW-1:0] OFS_CLR_TC   = 10'd2;
    localparam logic [WORD_AW-1:0] OFS_STAT_ERR = 10'd3;
    localparam logic [WORD_AW-1:0] OFS_CLR_ERR  = 10'd4;
    localparam logic [WORD_AW-1:0] OFS_RAW_TC   = 10'd5;
    localparam logic [WORD_AW-1:0] OFS_RAW_ERR  = 10'd6;
    localparam logic [WORD_AW-1:0] OFS_CH_ON    = 10'd7;
    localparam logic [WORD_AW-1:0] OFS_GCFG     = 10'd12;
    localparam logic [WORD_AW-1:0] OFS_SYNC     = 10'd13;

    // channel window: words 0x40..0x7F, 8 words per channel, config in slot 4
    localparam logic [3:0] CHAN_WIN_TAG = 4'b0001;
    localparam logic [2:0] CFG_SLOT     = 3'd4;
    // identification window: words 0x3F8..0x3FF
    localparam logic [6:0] ID_WIN_TAG   = 7'h7F;

    localparam int CFG_TCMASK_BIT  = 15;
    localparam int CFG_ERRMASK_BIT = 14;
    localparam int CFG_EN_BIT      = 0;
    localparam int GCFG_W          = 3;

    function automatic logic [7:0] id_byte(input logic [2:0] idx, input int nch);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = (nch > 2) ? 8'h80 : 8'h81;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h0A;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);

    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
    end

    // set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q & ~clr_eff) | set_i;
        end
    end

    assert_set_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));

    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && |(clr_mask & ~set_i)) |=> ((q & $past(clr_mask & ~set_i)) == '0));

endmodule

// File: rtl/dma_irq_chcfg.sv
module dma_irq_chcfg #(
    parameter int NUM_CH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [2:0]             ch_sel,
    input  logic [31:0]            wdata,
    output logic [NUM_CH-1:0][31:0] cfg_o,
    output logic [NUM_CH-1:0]      tc_mask_o,
    output logic [NUM_CH-1:0]      err_mask_o,
    output logic [NUM_CH-1:0]      en_o
);
    import dma_irq_pkg::*;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [31:0] word_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we && (ch_sel == 3'(c))) begin
                word_q <= wdata;
            end
        end

        assign cfg_o[c]      = word_q;
        assign tc_mask_o[c]  = word_q[CFG_TCMASK_BIT];
        assign err_mask_o[c] = word_q[CFG_ERRMASK_BIT];
        assign en_o[c]       = word_q[CFG_EN_BIT];

        assert_chan_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (we && (ch_sel == 3'(c))) |=> (en_o[c] == $past(wdata[0])));
    end

endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux #(
    parameter int NUM_CH = 8,
    parameter int SYNC_W = 16
) (
    input  logic [9:0]              addr,
    input  logic [NUM_CH-1:0]       tc_raw,
    input  logic [NUM_CH-1:0]       err_raw,
    input  logic [NUM_CH-1:0]       tc_mask,
    input  logic [NUM_CH-1:0]       err_mask,
    input  logic [NUM_CH-1:0][31:0] cfg,
    input  logic [NUM_CH-1:0]       ch_on,
    input  logic [2:0]              gcfg,
    input  logic [SYNC_W-1:0]       sync,
    output logic [31:0]             data,
    output logic                    hit
);
    import dma_irq_pkg::*;

    logic [NUM_CH-1:0] tc_vis;
    logic [NUM_CH-1:0] err_vis;
    logic [2:0]        ch_idx;
    logic [2:0]        slot;

    always_comb begin
        tc_vis  = tc_raw & tc_mask;
        err_vis = err_raw & err_mask;
        ch_idx  = addr[5:3];
        slot    = addr[2:0];
        data    = '0;
        hit     = 1'b0;
        if (addr[9:4] == 6'd0) begin
            unique case (addr[3:0])
                4'd0:  begin data = 32'(tc_vis | err_vis); hit = 1'b1; end
                4'd1:  begin data = 32'(tc_vis);           hit = 1'b1; end
                4'd3:  begin data = 32'(err_vis);          hit = 1'b1; end
                4'd5:  begin data = 32'(tc_raw);           hit = 1'b1; end
                4'd6:  begin data = 32'(err_raw);          hit = 1'b1; end
                4'd7:  begin data = 32'(ch_on);            hit = 1'b1; end
                4'd8, 4'd9, 4'd10, 4'd11: begin data = '0; hit = 1'b1; end
                4'd12: begin data = 32'(gcfg);             hit = 1'b1; end
                4'd13: begin data = 32'(sync);             hit = 1'b1; end
                default: begin data = '0; hit = 1'b0; end
            endcase
        end else if (addr[9:6] == CHAN_WIN_TAG) begin
            if (slot == CFG_SLOT) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (ch_idx == 3'(c)) begin
                        data = cfg[c];
                        hit  = 1'b1;
                    end
                end
            end
        end else if (addr[9:3] == ID_WIN_TAG) begin
            data = 32'(id_byte(addr[2:0], NUM_CH));
            hit  = 1'b1;
        end
    end

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs #(
    parameter int NUM_CH = 8,
    parameter int SYNC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [9:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rd_valid,
    output logic              slverr,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic [NUM_CH-1:0] err_set,
    output logic [NUM_CH-1:0] ch_enable,
    output logic              dma_on,
    output logic [1:0]        master_bigend,
    output logic [SYNC_W-1:0] sync_sel,
    output logic              irq
);
    import dma_irq_pkg::*;

    acc_state_t state_q;
    acc_state_t state_d;

    logic [NUM_CH-1:0]        tc_raw;
    logic [NUM_CH-1:0]        err_raw;
    logic [NUM_CH-1:0]        tc_mask;
    logic [NUM_CH-1:0]        err_mask;
    logic [NUM_CH-1:0][31:0]  cfg_words;
    logic [GCFG_W-1:0]        gcfg_q;
    logic [SYNC_W-1:0]        sync_q;
    logic [31:0]              mux_data;
    logic                     rd_hit;
    logic [31:0]              hold_q;

    logic clr_tc_we;
    logic clr_err_we;
    logic cfg_we;
    logic gcfg_we;
    logic sync_we;

    // write decode
    always_comb begin
        clr_tc_we  = wr_en && (addr == OFS_CLR_TC);
        clr_err_we = wr_en && (addr == OFS_CLR_ERR);
        gcfg_we    = wr_en && (addr == OFS_GCFG);
        sync_we    = wr_en && (addr == OFS_SYNC);
        cfg_we     = wr_en && (addr[9:6] == CHAN_WIN_TAG) && (addr[2:0] == CFG_SLOT)
                     && (int'(addr[5:3]) < NUM_CH);
    end

    dma_irq_flags #(.W(NUM_CH)) u_tc_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (tc_set),
        .clr_we   (clr_tc_we),
        .clr_mask (wdata[NUM_CH-1:0]),
        .q        (tc_raw)
    );

    dma_irq_flags #(.W(NUM_CH)) u_err_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (err_set),
        .clr_we   (clr_err_we),
        .clr_mask (wdata[NUM_CH-1:0]),
        .q        (err_raw)
    );

    dma_irq_chcfg #(.NUM_CH(NUM_CH)) u_chcfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .ch_sel     (addr[5:3]),
        .wdata      (wdata),
        .cfg_o      (cfg_words),
        .tc_mask_o  (tc_mask),
        .err_mask_o (err_mask),
        .en_o       (ch_enable)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcfg_q <= '0;
            sync_q <= '0;
        end else begin
            if (gcfg_we) gcfg_q <= wdata[GCFG_W-1:0];
            if (sync_we) sync_q <= wdata[SYNC_W-1:0];
        end
    end

    assign dma_on        = gcfg_q[0];
    assign master_bigend = gcfg_q[2:1];
    assign sync_sel      = sync_q;
    assign irq           = |((tc_raw & tc_mask) | (err_raw & err_mask));

    dma_irq_rdmux #(.NUM_CH(NUM_CH), .SYNC_W(SYNC_W)) u_rdmux (
        .addr     (addr),
        .tc_raw   (tc_raw),
        .err_raw  (err_raw),
        .tc_mask  (tc_mask),
        .err_mask (err_mask),
        .cfg      (cfg_words),
        .ch_on    (ch_enable),
        .gcfg     (gcfg_q),
        .sync     (sync_q),
        .data     (mux_data),
        .hit      (rd_hit)
    );

    // access FSM: next-state logic
    always_comb begin
        state_d = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_DATA, ACC_FAULT: begin
                if (rd_en) state_d = rd_hit ? ACC_DATA : ACC_FAULT;
                else       state_d = ACC_IDLE;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    // access FSM: state register and captured read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) hold_q <= rd_hit ? mux_data : '0;
        end
    end

    // access FSM: outputs
    always_comb begin
        rd_valid = 1'b0;
        slverr   = 1'b0;
        rdata    = '0;
        unique case (state_q)
            ACC_IDLE:  ;
            ACC_DATA:  begin rd_valid = 1'b1; rdata = hold_q; end
            ACC_FAULT: begin rd_valid = 1'b1; slverr = 1'b1; end
            default:   ;
        endcase
    end

    assert_fault_resp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit) |=> (slverr && rd_valid && (rdata == '0)));

    assert_no_stray_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_irq_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((|tc_set) || (|err_set) || wr_en));

    assert_irq_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en));

endmodule

// File: tb/test_dma_irq_regs.sv
module test_dma_irq_regs;

    localparam int NCH = 8;
    localparam int SW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [9:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rd_valid;
    logic              slverr;
    logic [NCH-1:0]    tc_set = '0;
    logic [NCH-1:0]    err_set = '0;
    logic [NCH-1:0]    ch_enable;
    logic              dma_on;
    logic [1:0]        master_bigend;
    logic [SW-1:0]     sync_sel;
    logic              irq;

    always #5 clk = ~clk;

    dma_irq_regs #(.NUM_CH(NCH), .SYNC_W(SW)) i_dma_irq_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .slverr(slverr),
        .tc_set(tc_set), .err_set(err_set), .ch_enable(ch_enable), .dma_on(dma_on),
        .master_bigend(master_bigend), .sync_sel(sync_sel), .irq(irq)
    );

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // reference model of software-visible state
    logic [NCH-1:0] m_tc = '0;
    logic [NCH-1:0] m_err = '0;
    logic [31:0]    m_cfg [NCH];
    logic [2:0]     m_g = '0;
    logic [SW-1:0]  m_sync = '0;
    logic [7:0]     id_tab [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] m_tcmask();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_cfg[c][15];
        return v;
    endfunction

    function automatic logic [NCH-1:0] m_errmask();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_cfg[c][14];
        return v;
    endfunction

    function automatic logic [NCH-1:0] m_en();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_cfg[c][0];
        return v;
    endfunction

    // {hit, data} expected for a word offset
    function automatic logic [32:0] exp_read(input int a);
        logic [NCH-1:0] tv;
        logic [NCH-1:0] ev;
        tv = m_tc & m_tcmask();
        ev = m_err & m_errmask();
        if (a < 16) begin
            case (a)
                0:  return {1'b1, 32'(tv | ev)};
                1:  return {1'b1, 32'(tv)};
                3:  return {1'b1, 32'(ev)};
                5:  return {1'b1, 32'(m_tc)};
                6:  return {1'b1, 32'(m_err)};
                7:  return {1'b1, 32'(m_en())};
                8, 9, 10, 11: return {1'b1, 32'd0};
                12: return {1'b1, 32'(m_g)};
                13: return {1'b1, 32'(m_sync)};
                default: return {1'b0, 32'd0};
            endcase
        end
        if (a >= 64 && a < 128) begin
            if ((a % 8) == 4 && ((a - 64) / 8) < NCH) return {1'b1, m_cfg[(a - 64) / 8]};
            return {1'b0, 32'd0};
        end
        if (a >= 1016) return {1'b1, 24'd0, id_tab[a - 1016]};
        return {1'b0, 32'd0};
    endfunction

    function automatic string tag_of(input int a);
        if (a >= 1016) return "R11";
        if (a >= 64 && a < 128) return "R8/R13";
        if (a >= 8 && a <= 11) return "R10";
        if (a == 12 || a == 13) return "R9";
        if (a == 5 || a == 6) return "R7";
        if (a == 7) return "R8";
        if (a < 4 && a != 2) return "R5";
        return "R13";
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 10'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d, output logic e, output logic v);
        @(negedge clk);
        rd_en = 1'b1; addr = 10'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; e = slverr; v = rd_valid;
    endtask

    task automatic rd_check(input int a, input string req);
        logic [31:0] d; logic e; logic v;
        logic [32:0] x;
        rd(a, d, e, v);
        x = exp_read(a);
        check($sformatf("%s R12 word %0d {valid,err,data}", req, a), {30'd0, v, e, d}, {30'd0, 1'b1, ~x[32], x[31:0]});
    endtask

    task automatic sweep(input string why);
        for (int a = 0; a < 1024; a++) rd_check(a, $sformatf("%s %s", why, tag_of(a)));
    endtask

    task automatic set_cfg(input int c, input logic [31:0] d);
        wr(68 + 8 * c, d);
        m_cfg[c] = d;
    endtask

    task automatic pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] e);
        @(negedge clk);
        tc_set = t; err_set = e;
        @(negedge clk);
        tc_set = '0; err_set = '0;
        m_tc |= t; m_err |= e;
    endtask

    task automatic chk_irq(input string req);
        logic exp;
        exp = |((m_tc & m_tcmask()) | (m_err & m_errmask()));
        check($sformatf("%s R6 irq", req), 64'(irq), 64'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d; logic e; logic v;
        for (int c = 0; c < NCH; c++) m_cfg[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports
        check("R1 irq", 64'(irq), 64'd0);
        check("R1 rd_valid/slverr", {62'd0, rd_valid, slverr}, 64'd0);
        check("R1 outputs", {37'd0, ch_enable, dma_on, master_bigend, sync_sel}, 64'd0);
        sweep("R1 reset sweep");

        // R2 R5 R6 R7: every channel, every mask combination
        for (int c = 0; c < NCH; c++) begin
            for (int m = 0; m < 4; m++) begin
                set_cfg(c, (32'(m >> 1) << 15) | (32'(m & 1) << 14) | 32'h1);
                check("R8 ch_enable", 64'(ch_enable), 64'(m_en()));
                pulse(NCH'(1) << c, '0);
                chk_irq("R2 tc");
                rd_check(5, "R2 R7 raw tc");
                rd_check(1, "R5 masked tc");
                pulse('0, NCH'(1) << c);
                chk_irq("R2 err");
                rd_check(6, "R2 R7 raw err");
                rd_check(3, "R5 masked err");
                rd_check(0, "R5 combined");
                wr(2, 32'hFFFF_FFFF); m_tc = '0;
                wr(4, 32'hFFFF_FFFF); m_err = '0;
                chk_irq("R3 after clear");
                rd_check(0, "R3 cleared");
            end
            set_cfg(c, 32'h0000_C000 | 32'(c) << 20);
        end

        // R3: partial clear patterns
        pulse('1, '1);
        wr(2, 32'hA5); m_tc &= ~8'hA5;
        rd_check(5, "R3 partial tc");
        wr(4, 32'h3C); m_err &= ~8'h3C;
        rd_check(6, "R3 partial err");
        chk_irq("R3 partial");

        // R4: set and clear of the same bit in one cycle
        wr(2, 32'hFF); m_tc = '0;
        @(negedge clk);
        wr_en = 1'b1; addr = 10'd2; wdata = 32'hFF; tc_set = 8'h11;
        @(negedge clk);
        wr_en = 1'b0; tc_set = '0;
        m_tc = 8'h11;
        rd_check(5, "R4 set wins tc");
        @(negedge clk);
        wr_en = 1'b1; addr = 10'd4; wdata = 32'hFF; err_set = 8'h80;
        @(negedge clk);
        wr_en = 1'b0; err_set = '0;
        m_err = 8'h80;
        rd_check(6, "R4 set wins err");

        // R9: global configuration and sync
        wr(12, 32'hFFFF_FFFF); m_g = 3'b111;
        check("R9 dma_on/bigend", {61'd0, dma_on, master_bigend}, 64'd7);
        wr(12, 32'h0000_0004); m_g = 3'b100;
        check("R9 bigend only", {61'd0, dma_on, master_bigend}, 64'd2);
        wr(13, 32'hFFFF_1234); m_sync = 16'h1234;
        check("R9 sync_sel", 64'(sync_sel), 64'h1234);

        // R10 R13: ignored writes
        for (int a = 8; a <= 11; a++) wr(a, 32'hFFFF_FFFF);
        wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
        wr(14, 32'hFFFF_FFFF); wr(64, 32'hFFFF_FFFF); wr(71, 32'hFFFF_FFFF);
        wr(200, 32'hFFFF_FFFF); wr(1016, 32'hFFFF_FFFF);
        sweep("R10 R13 after ignored writes");
        check("R13 outputs unchanged", {37'd0, ch_enable, dma_on, master_bigend, sync_sel},
              {37'd0, m_en(), m_g[0], m_g[2:1], m_sync});

        // R13: error lasts one cycle only
        rd(2, d, e, v);
        check("R13 fault on clear word", {62'd0, e, v}, 64'd3);
        @(negedge clk);
        check("R12 R13 no response after", {62'd0, slverr, rd_valid}, 64'd0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule